// File: doc/BRIEF.md
# Nibble Accumulator Datapath with Carry

This block is the register-and-arithmetic core of a small 4-bit controller. It keeps a 4-bit accumulator, a carry flag, a 4-bit scratch register, an 8-bit wide register and a 3-bit page-offset pointer. An already-decoded 4-bit operation code arrives each clock, together with a 4-bit immediate and a 4-bit memory nibble. One operation is carried out per clock.

The operations are three kinds of addition, a right rotation through the carry, carry set and clear, register transfers, a pointer load and a two-cycle table read. The table read forms a 7-bit in-page ROM address from the pointer and the accumulator. It then splits the returned ROM word across the accumulator and the scratch register. Fetch, decode, RAM addressing and I/O are handled elsewhere.

Top module: `nib_core`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `acc_o`, `cy_o`, `b_o`, `e_o`, `d_o` and `busy_o` are all 0.
- R2: Code 1 (add with carry) writes the low 4 bits of `acc_o + mem_i + cy_o` to the accumulator and writes the fifth bit to the carry flag.
- R3: Code 2 adds `imm_i` to the accumulator and code 3 adds `mem_i` to it, both modulo 16. Neither changes the carry flag.
- R4: Code 4 rotates right through carry. Old bit 0 of the accumulator goes to the carry, the old carry goes to bit 3, and bits 3..1 move down one place.
- R5: Code 5 sets the carry flag to 1 and code 6 clears it to 0.
- R6: Code 7 copies the accumulator into B. Code 8 copies B into the accumulator.
- R7: Code 9 loads E with B in bits 7:4 and the accumulator in bits 3:0. Code 10 loads B from E bits 7:4 and the accumulator from E bits 3:0.
- R8: Code 11 loads the pointer D from `imm_i[2:0]`.
- R9: Code 12 starts a table read. For exactly one following cycle, `busy_o` and `rom_rd_o` are 1, `rom_addr_o` equals {D, accumulator}, with D in bits 6:4, and `rom_page_o` equals the `imm_i` given with code 12.
- R10: At the end of the busy cycle, `rom_data_i[3:0]` loads the accumulator and `rom_data_i[7:4]` loads B. The carry, E and D keep their values, and `busy_o` returns to 0.
- R11: An operation code presented while `busy_o` is 1 has no effect.
- R12: Code 0 and the unused codes 13 to 15 leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Decoded operation code |
| imm_i | input | 4 | Immediate field (add value, pointer value, table page) |
| mem_i | input | 4 | Memory nibble operand |
| rom_data_i | input | ROM_W (8) | ROM word returned for a table read |
| rom_rd_o | output | 1 | Table read address valid |
| rom_addr_o | output | 7 | In-page ROM address {D, accumulator} |
| rom_page_o | output | 4 | ROM page for the table read |
| busy_o | output | 1 | Table read in its second cycle |
| acc_o | output | 4 | Accumulator |
| cy_o | output | 1 | Carry flag |
| b_o | output | 4 | Scratch register B |
| e_o | output | 8 | Register E |
| d_o | output | 3 | Pointer register D |

## Verification
The assertions assume that `rom_data_i` is a combinational function of `rom_page_o` and `rom_addr_o` and is valid during the busy cycle. They also assume that `mem_i` and `op_i` are steady around each rising edge. The bench drives every input on the falling edge and models the ROM as a fixed arithmetic function of page and address. This keeps the returned word consistent with the address shown. Codes are sent both while the block is idle and during the busy cycle, so the assertions on ignored codes are exercised under the same input conditions they assume.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int NIB_W = 4;

  localparam logic [3:0] OP_NOP   = 4'd0;
  localparam logic [3:0] OP_ADDC  = 4'd1;
  localparam logic [3:0] OP_ADDI  = 4'd2;
  localparam logic [3:0] OP_ADDM  = 4'd3;
  localparam logic [3:0] OP_ROTR  = 4'd4;
  localparam logic [3:0] OP_SETC  = 4'd5;
  localparam logic [3:0] OP_CLRC  = 4'd6;
  localparam logic [3:0] OP_A2B   = 4'd7;
  localparam logic [3:0] OP_B2A   = 4'd8;
  localparam logic [3:0] OP_AB2E  = 4'd9;
  localparam logic [3:0] OP_E2AB  = 4'd10;
  localparam logic [3:0] OP_LDD   = 4'd11;
  localparam logic [3:0] OP_TLOOK = 4'd12;

  // {carry_out, sum} of two nibbles and a carry in
  function automatic logic [NIB_W:0] nib_sum(input logic [NIB_W-1:0] x,
                                             input logic [NIB_W-1:0] y,
                                             input logic cin);
    return {1'b0, x} + {1'b0, y} + {{NIB_W{1'b0}}, cin};
  endfunction

  // {new_carry, new_acc} of a right rotation through carry
  function automatic logic [NIB_W:0] nib_rotr(input logic [NIB_W-1:0] a,
                                              input logic cin);
    return {a[0], cin, a[NIB_W-1:1]};
  endfunction
endpackage

// File: rtl/nib_arith.sv
module nib_arith
  import nib_pkg::*;
(
  input  logic [3:0]       op,
  input  logic [NIB_W-1:0] a,
  input  logic             cy,
  input  logic [NIB_W-1:0] mem,
  input  logic [NIB_W-1:0] imm,
  output logic             a_we,
  output logic [NIB_W-1:0] a_nxt,
  output logic             cy_we,
  output logic             cy_nxt
);
  logic [NIB_W:0] sum_c, sum_i, sum_m, rot;

  assign sum_c = nib_sum(a, mem, cy);
  assign sum_i = nib_sum(a, imm, 1'b0);
  assign sum_m = nib_sum(a, mem, 1'b0);
  assign rot   = nib_rotr(a, cy);

  always_comb begin
    a_we   = 1'b0;
    a_nxt  = a;
    cy_we  = 1'b0;
    cy_nxt = cy;
    case (op)
      OP_ADDC: begin a_we = 1'b1; a_nxt = sum_c[NIB_W-1:0];
                     cy_we = 1'b1; cy_nxt = sum_c[NIB_W]; end
      OP_ADDI: begin a_we = 1'b1; a_nxt = sum_i[NIB_W-1:0]; end
      OP_ADDM: begin a_we = 1'b1; a_nxt = sum_m[NIB_W-1:0]; end
      OP_ROTR: begin a_we = 1'b1; a_nxt = rot[NIB_W-1:0];
                     cy_we = 1'b1; cy_nxt = rot[NIB_W]; end
      OP_SETC: begin cy_we = 1'b1; cy_nxt = 1'b1; end
      OP_CLRC: begin cy_we = 1'b1; cy_nxt = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/nib_xfer.sv
module nib_xfer
  import nib_pkg::*;
#(
  parameter int D_W = 3
) (
  input  logic [3:0]         op,
  input  logic [NIB_W-1:0]   a,
  input  logic [NIB_W-1:0]   b,
  input  logic [2*NIB_W-1:0] e,
  input  logic [D_W-1:0]     imm_d,
  output logic               a_we,
  output logic [NIB_W-1:0]   a_nxt,
  output logic               b_we,
  output logic [NIB_W-1:0]   b_nxt,
  output logic               e_we,
  output logic [2*NIB_W-1:0] e_nxt,
  output logic               d_we,
  output logic [D_W-1:0]     d_nxt
);
  always_comb begin
    a_we  = 1'b0; a_nxt = a;
    b_we  = 1'b0; b_nxt = b;
    e_we  = 1'b0; e_nxt = e;
    d_we  = 1'b0; d_nxt = imm_d;
    case (op)
      OP_A2B:  begin b_we = 1'b1; b_nxt = a; end
      OP_B2A:  begin a_we = 1'b1; a_nxt = b; end
      OP_AB2E: begin e_we = 1'b1; e_nxt = {b, a}; end
      OP_E2AB: begin b_we = 1'b1; b_nxt = e[2*NIB_W-1:NIB_W];
                     a_we = 1'b1; a_nxt = e[NIB_W-1:0]; end
      OP_LDD:  d_we = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/nib_lookup.sv
module nib_lookup
  import nib_pkg::*;
#(
  parameter int D_W   = 3,
  parameter int ROM_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [D_W-1:0]       d,
  input  logic [NIB_W-1:0]     a,
  input  logic [NIB_W-1:0]     imm,
  input  logic [ROM_W-1:0]     rom_data,
  output logic                 busy,
  output logic [D_W+NIB_W-1:0] addr,
  output logic [NIB_W-1:0]     page,
  output logic                 load,
  output logic [NIB_W-1:0]     lo,
  output logic [NIB_W-1:0]     mid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      addr <= '0;
      page <= '0;
    end else if (busy) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      addr <= {d, a};
      page <= imm;
    end
  end

  assign load = busy;
  assign lo   = rom_data[NIB_W-1:0];
  assign mid  = rom_data[2*NIB_W-1:NIB_W];

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy); // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && page == $past(imm))); // R9
endmodule

// File: rtl/nib_core.sv
module nib_core
  import nib_pkg::*;
#(
  parameter int D_W   = 3,
  parameter int ROM_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           op_i,
  input  logic [3:0]           imm_i,
  input  logic [3:0]           mem_i,
  input  logic [ROM_W-1:0]     rom_data_i,
  output logic                 rom_rd_o,
  output logic [D_W+3:0]       rom_addr_o,
  output logic [3:0]           rom_page_o,
  output logic                 busy_o,
  output logic [3:0]           acc_o,
  output logic                 cy_o,
  output logic [3:0]           b_o,
  output logic [7:0]           e_o,
  output logic [D_W-1:0]       d_o
);
  localparam int EW = 2 * NIB_W;

  logic [NIB_W-1:0] acc_q, b_q;
  logic             cy_q;
  logic [EW-1:0]    e_q;
  logic [D_W-1:0]   d_q;

  // operation actually executed this cycle: codes are dropped while busy
  logic [3:0] op_eff;
  logic       busy;
  assign op_eff = busy ? OP_NOP : op_i;

  logic             ar_a_we, ar_cy_we, ar_cy_nxt;
  logic [NIB_W-1:0] ar_a_nxt;
  nib_arith u_arith (
    .op(op_eff), .a(acc_q), .cy(cy_q), .mem(mem_i), .imm(imm_i),
    .a_we(ar_a_we), .a_nxt(ar_a_nxt), .cy_we(ar_cy_we), .cy_nxt(ar_cy_nxt)
  );

  logic             xf_a_we, xf_b_we, xf_e_we, xf_d_we;
  logic [NIB_W-1:0] xf_a_nxt, xf_b_nxt;
  logic [EW-1:0]    xf_e_nxt;
  logic [D_W-1:0]   xf_d_nxt;
  nib_xfer #(.D_W(D_W)) u_xfer (
    .op(op_eff), .a(acc_q), .b(b_q), .e(e_q), .imm_d(imm_i[D_W-1:0]),
    .a_we(xf_a_we), .a_nxt(xf_a_nxt), .b_we(xf_b_we), .b_nxt(xf_b_nxt),
    .e_we(xf_e_we), .e_nxt(xf_e_nxt), .d_we(xf_d_we), .d_nxt(xf_d_nxt)
  );

  logic             lk_load;
  logic [NIB_W-1:0] lk_lo, lk_mid;
  nib_lookup #(.D_W(D_W), .ROM_W(ROM_W)) u_lookup (
    .clk(clk), .rst_n(rst_n), .start(op_eff == OP_TLOOK),
    .d(d_q), .a(acc_q), .imm(imm_i), .rom_data(rom_data_i),
    .busy(busy), .addr(rom_addr_o), .page(rom_page_o),
    .load(lk_load), .lo(lk_lo), .mid(lk_mid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      b_q   <= '0;
      cy_q  <= 1'b0;
      e_q   <= '0;
      d_q   <= '0;
    end else begin
      if (lk_load)       acc_q <= lk_lo;
      else if (ar_a_we)  acc_q <= ar_a_nxt;
      else if (xf_a_we)  acc_q <= xf_a_nxt;
      if (lk_load)       b_q <= lk_mid;
      else if (xf_b_we)  b_q <= xf_b_nxt;
      if (ar_cy_we)      cy_q <= ar_cy_nxt;
      if (xf_e_we)       e_q <= xf_e_nxt;
      if (xf_d_we)       d_q <= xf_d_nxt;
    end
  end

  assign acc_o    = acc_q;
  assign b_o      = b_q;
  assign cy_o     = cy_q;
  assign e_o      = e_q;
  assign d_o      = d_q;
  assign busy_o   = busy;
  assign rom_rd_o = busy;

  AST_ADDC_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_eff == OP_ADDC) |=> ({cy_o, acc_o} ==
      $past({1'b0, acc_o} + {1'b0, mem_i} + {4'b0, cy_o}))); // R2
  AST_ADD_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_eff == OP_ADDI || op_eff == OP_ADDM) |=> $stable(cy_o)); // R3
  AST_ROTR_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (op_eff == OP_ROTR) |=> (cy_o == $past(acc_o[0]) && acc_o[3] == $past(cy_o))); // R4
  AST_SETC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_eff == OP_SETC) |=> cy_o); // R5
  AST_CLRC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_eff == OP_CLRC) |=> !cy_o); // R5
  AST_LOOK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (rom_rd_o && rom_addr_o == {d_o, acc_o})); // R9
  AST_LOOK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(cy_o) && $stable(e_o) && $stable(d_o))); // R10
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_eff == OP_NOP && !busy_o) |=>
      $stable({acc_o, b_o, e_o, d_o, cy_o, busy_o})); // R12
endmodule

// File: tb/nib_core_bench.sv
module nib_core_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n;
  logic [3:0] op_i, imm_i, mem_i;
  logic [7:0] rom_data_i;
  logic       rom_rd_o, busy_o, cy_o;
  logic [6:0] rom_addr_o;
  logic [3:0] rom_page_o, acc_o, b_o;
  logic [7:0] e_o;
  logic [2:0] d_o;

  nib_core u_nib_core (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .imm_i(imm_i), .mem_i(mem_i),
    .rom_data_i(rom_data_i), .rom_rd_o(rom_rd_o), .rom_addr_o(rom_addr_o),
    .rom_page_o(rom_page_o), .busy_o(busy_o), .acc_o(acc_o), .cy_o(cy_o),
    .b_o(b_o), .e_o(e_o), .d_o(d_o)
  );

  function automatic int romf(int p, int ad);
    return (p * 73 + ad * 29 + 17) % 256;
  endfunction
  assign rom_data_i = 8'(romf(int'(rom_page_o), int'(rom_addr_o)));

  int total = 0, bad = 0;
  int ma = 0, mb = 0, me = 0, md = 0, mc = 0, mbusy = 0, maddr = 0, mpage = 0;
  bit finished = 0;

  function automatic string tag_of(int op, int was_busy);
    if (was_busy) return "R10 R11";
    case (op)
      1: return "R2";  2, 3: return "R3";  4: return "R4";
      5, 6: return "R5"; 7, 8: return "R6"; 9, 10: return "R7";
      11: return "R8"; 12: return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag);
    bit ok;
    ok = (int'(acc_o) == ma) && (int'(cy_o) == mc) && (int'(b_o) == mb) &&
         (int'(e_o) == me) && (int'(d_o) == md) && (int'(busy_o) == mbusy) &&
         (int'(rom_rd_o) == mbusy);
    if (mbusy) ok = ok && (int'(rom_addr_o) == maddr) && (int'(rom_page_o) == mpage);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act a=%0h c=%0d b=%0h e=%0h d=%0d busy=%0d addr=%0h pg=%0h exp a=%0h c=%0d b=%0h e=%0h d=%0d busy=%0d addr=%0h pg=%0h",
               tag, acc_o, cy_o, b_o, e_o, d_o, busy_o, rom_addr_o, rom_page_o,
               ma, mc, mb, me, md, mbusy, maddr, mpage);
    end
  endtask

  // called on a falling edge: drive, predict the next state, check one cycle later
  task automatic step(int op, int imm, int mem);
    int s, t, rd, wb;
    op_i = 4'(op); imm_i = 4'(imm); mem_i = 4'(mem);
    wb = mbusy;
    if (mbusy) begin
      rd = romf(mpage, maddr);
      ma = rd & 15; mb = (rd >> 4) & 15; mbusy = 0;
    end else begin
      case (op)
        1: begin s = ma + mem + mc; ma = s & 15; mc = s >> 4; end
        2: ma = (ma + imm) & 15;
        3: ma = (ma + mem) & 15;
        4: begin t = ma & 1; ma = (ma >> 1) | (mc << 3); mc = t; end
        5: mc = 1;
        6: mc = 0;
        7: mb = ma;
        8: ma = mb;
        9: me = mb * 16 + ma;
        10: begin mb = me >> 4; ma = me & 15; end
        11: md = imm & 7;
        12: begin maddr = md * 16 + ma; mpage = imm; mbusy = 1; end
        default: ;
      endcase
    end
    @(negedge clk);
    check(tag_of(op, wb));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_i = 4'd5; imm_i = 4'd7; mem_i = 4'd9;
    repeat (3) @(negedge clk);
    check("R1");                     // code 5 under reset has no effect
    rst_n = 1'b1; op_i = 4'd0;
    @(negedge clk);
    check("R1");
    // R2 corner: 15 + 15 + 1
    step(2, 15, 0); step(5, 0, 0); step(1, 0, 15);
    step(1, 0, 0);                   // 15+0+1 -> 0, carry 1
    step(1, 0, 0);                   // 0+0+1 -> 1, carry 0
    // R3 wrap without carry change
    step(5, 0, 0); step(2, 15, 0); step(3, 0, 14);
    step(6, 0, 0); step(2, 9, 0); step(3, 0, 12);
    // R4 rotations
    step(5, 0, 0); step(4, 0, 0); step(4, 0, 0); step(4, 0, 0); step(4, 0, 0); step(4, 0, 0);
    // R6, R7
    step(2, 3, 0); step(7, 0, 0); step(2, 8, 0); step(9, 0, 0);
    step(8, 0, 0); step(2, 1, 0); step(10, 0, 0);
    // R8, R9, R10 with R11 (code sent during busy)
    step(11, 13, 0); step(12, 9, 0); step(2, 5, 0);
    step(11, 7, 0); step(2, 15, 0); step(12, 15, 0); step(5, 0, 0);
    // R12 unused codes
    step(13, 4, 4); step(14, 4, 4); step(15, 4, 4); step(0, 4, 4);
    for (int i = 0; i < 4000; i++)
      step(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule